// File: doc/BRIEF.md
# Iterative Integer Multiplier with High-Half Products

This block multiplies two register-width operands for a processor datapath and returns either the lower or the upper half of the double-width product. One shared product engine serves every result. A 3-bit operation code picks the low half or one of three high-half variants, which differ only in whether each operand is read as signed or as unsigned. A word-mode flag narrows the multiply to the lower `WORD_W` bits of each operand and sign-extends the narrow result to the full width.

The engine is a radix-2^`CHUNK_W` shift-and-add unit. It works on operand magnitudes and applies the result sign at the end, so it takes `XLEN/CHUNK_W` step cycles per product. A one-entry reuse register keeps the last full-width product together with its operands and its signedness. A software sequence that asks for a high half and then the low half of the same product gets the second answer on the cycle after acceptance, without running the engine again. Requests enter and results leave through valid/ready handshakes. The unit holds one operation at a time.

Top module: `mul_unit`

## Requirements
- R1: Operation code 3'b000 returns bits [XLEN-1:0] of the product of the two operands.
- R2: Operation code 3'b001 returns bits [2*XLEN-1:XLEN] of the product with both operands signed. This includes most-negative times most-negative and most-negative times all-ones.
- R3: Operation code 3'b010 returns bits [2*XLEN-1:XLEN] of the product with the first operand signed and the second unsigned.
- R4: Operation code 3'b011 returns bits [2*XLEN-1:XLEN] of the unsigned product.
- R5: With word_i high, only bits [WORD_W-1:0] of each operand are multiplied. The result is bits [WORD_W-1:0] of that product, sign-extended to XLEN. The operation code and the upper operand bits have no effect.
- R6: Operation codes 3'b100 to 3'b111 behave exactly like 3'b000.
- R7: in_ready_o is high only when no operation is in progress and no result is pending. A request is taken on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o returns high on the cycle after the result is taken.
- R8: The result is presented with out_valid_o and stays stable until a clock edge with out_ready_i high takes it.
- R9: A request that has to be computed raises out_valid_o exactly XLEN/CHUNK_W + 1 cycles after the edge that accepted it.
- R10: A request in full-width mode reuses the stored product and raises out_valid_o on the cycle after acceptance when two conditions hold. First, its operands equal those of the last computed full-width request. Second, it asks for the low half, or for a high half with the same signedness as the stored product.
- R11: Reset, a word-mode request, or a computed request with different operands or signedness replaces or invalidates the stored product. The next request is then computed at full latency.
- R12: During and right after reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can accept a request |
| a_i | input | XLEN | First operand (multiplicand) |
| b_i | input | XLEN | Second operand (multiplier) |
| op_i | input | 3 | Operation code (low, high ss, high su, high uu) |
| word_i | input | 1 | Narrow word mode |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | XLEN | Result |

## Verification
The bound checker checks the handshake rules on every cycle: a held result stays stable, a request is never accepted while a result is pending, in_ready_o drops after acceptance and comes back after the result is taken, and word-mode results are sign-extended. The arithmetic of each product variant, the exact latency of a computed request against a reused one, and the conditions that invalidate the reuse register can only be shown by the bench scenarios. The bench runs a reduced 8-bit configuration and sweeps a spread of operand pairs across every operation code. It then steps through ordered request sequences that must hit or miss the stored product.

// File: rtl/mul_unit_pkg.sv
package mul_unit_pkg;
  typedef enum logic [1:0] {
    MD_LO = 2'd0,
    MD_SS = 2'd1,
    MD_SU = 2'd2,
    MD_UU = 2'd3
  } mul_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_OUT  = 2'd2
  } mul_state_e;

  function automatic mul_mode_e decode_op(input logic [2:0] op, input logic word);
    mul_mode_e m;
    if (word || op[2]) m = MD_LO;
    else begin
      case (op[1:0])
        2'b01:   m = MD_SS;
        2'b10:   m = MD_SU;
        2'b11:   m = MD_UU;
        default: m = MD_LO;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/mul_sign_mag.sv
module mul_sign_mag #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [XLEN-1:0] x_i,
  input  logic            word_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] mag_o,
  output logic            neg_o
);
  always_comb begin
    if (word_i) begin
      mag_o = {{(XLEN-WORD_W){1'b0}}, x_i[WORD_W-1:0]};
      neg_o = 1'b0;
    end else if (signed_i && x_i[XLEN-1]) begin
      mag_o = -x_i;
      neg_o = 1'b1;
    end else begin
      mag_o = x_i;
      neg_o = 1'b0;
    end
  end
endmodule

// File: rtl/mul_iter_engine.sv
module mul_iter_engine #(
  parameter int XLEN    = 64,
  parameter int CHUNK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  input  logic              neg_i,
  output logic              done_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int STEPS = XLEN / CHUNK_W;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int PW    = 2 * XLEN;

  logic             busy_q, fin_q, neg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    acc_q, mcand_q, pp;
  logic [XLEN-1:0]  mplier_q;

  // partial product of the current multiplier digit
  always_comb begin
    pp = '0;
    for (int k = 0; k < CHUNK_W; k++) begin
      if (mplier_q[k]) pp = pp + (mcand_q << k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      neg_q    <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      fin_q    <= 1'b0;
      neg_q    <= neg_i;
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= {{XLEN{1'b0}}, mcand_i};
      mplier_q <= mplier_i;
    end else if (busy_q) begin
      acc_q    <= acc_q + pp;
      mcand_q  <= mcand_q << CHUNK_W;
      mplier_q <= mplier_q >> CHUNK_W;
      cnt_q    <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STEPS - 1)) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign done_o = fin_q;
  assign prod_o = neg_q ? -acc_q : acc_q;
endmodule

// File: rtl/mul_reuse_cache.sv
module mul_reuse_cache
  import mul_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  mul_mode_e         mode_i,
  input  logic              word_i,
  input  logic              lookup_i,
  input  logic              fill_i,
  input  logic [2*XLEN-1:0] fill_prod_i,
  output logic              hit_o,
  output logic [2*XLEN-1:0] prod_o
);
  logic              valid_q;
  logic [XLEN-1:0]   tag_a_q, tag_b_q;
  mul_mode_e         tag_mode_q;
  logic [2*XLEN-1:0] prod_q;

  assign hit_o = valid_q && !word_i && (a_i == tag_a_q) && (b_i == tag_b_q)
              && ((mode_i == MD_LO) || (mode_i == tag_mode_q));
  assign prod_o = prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      tag_a_q    <= '0;
      tag_b_q    <= '0;
      tag_mode_q <= MD_LO;
      prod_q     <= '0;
    end else if (lookup_i && !hit_o) begin
      valid_q    <= 1'b0;
      tag_a_q    <= a_i;
      tag_b_q    <= b_i;
      tag_mode_q <= mode_i;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      prod_q  <= fill_prod_i;
    end
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_unit_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      op_i,
  input  logic            word_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] res_o
);
  localparam int PW = 2 * XLEN;

  mul_state_e      state_q;
  mul_mode_e       mode, mode_q;
  logic            word_q, accept, hit, eng_done;
  logic [XLEN-1:0] res_q;
  logic [PW-1:0]   eng_prod, cache_prod;
  logic [1:0]      opnd_signed, opnd_neg;
  logic [XLEN-1:0] opnd [2];
  logic [XLEN-1:0] mag  [2];

  assign mode           = decode_op(op_i, word_i);
  assign accept         = in_valid_i && (state_q == ST_IDLE);
  assign opnd[0]        = a_i;
  assign opnd[1]        = b_i;
  assign opnd_signed[0] = (mode == MD_SS) || (mode == MD_SU);
  assign opnd_signed[1] = (mode == MD_SS);

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    mul_sign_mag #(.XLEN(XLEN), .WORD_W(WORD_W)) u_sm (
      .x_i     (opnd[g]),
      .word_i  (word_i),
      .signed_i(opnd_signed[g]),
      .mag_o   (mag[g]),
      .neg_o   (opnd_neg[g])
    );
  end

  mul_iter_engine #(.XLEN(XLEN), .CHUNK_W(CHUNK_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && !hit),
    .mcand_i (mag[0]),
    .mplier_i(mag[1]),
    .neg_i   (opnd_neg[0] ^ opnd_neg[1]),
    .done_o  (eng_done),
    .prod_o  (eng_prod)
  );

  mul_reuse_cache #(.XLEN(XLEN)) u_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (a_i),
    .b_i        (b_i),
    .mode_i     (mode),
    .word_i     (word_i),
    .lookup_i   (accept),
    .fill_i     (eng_done && !word_q),
    .fill_prod_i(eng_prod),
    .hit_o      (hit),
    .prod_o     (cache_prod)
  );

  function automatic logic [XLEN-1:0] pick(input logic [PW-1:0] p, input mul_mode_e m,
                                           input logic w);
    if (w) return {{(XLEN-WORD_W){p[WORD_W-1]}}, p[WORD_W-1:0]};
    if (m == MD_LO) return p[XLEN-1:0];
    return p[PW-1:XLEN];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_LO;
      word_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          mode_q <= mode;
          word_q <= word_i;
          if (hit) begin
            res_q   <= pick(cache_prod, mode, 1'b0);
            state_q <= ST_OUT;
          end else begin
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: if (eng_done) begin
          res_q   <= pick(eng_prod, mode_q, word_q);
          state_q <= ST_OUT;
        end
        ST_OUT: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_OUT);
  assign res_o       = res_q;
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            word_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [XLEN-1:0] res_o
);
  logic word_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_seen_q <= 1'b0;
    else if (in_valid_i && in_ready_o) word_seen_q <= word_i;
  end

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  p_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (in_ready_o && !out_valid_o));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_o)));

  p_word_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && word_seen_q) |->
      (res_o[XLEN-1:WORD_W] == {(XLEN-WORD_W){res_o[WORD_W-1]}}));
endmodule

bind mul_unit mul_unit_chk #(.XLEN(XLEN), .WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .word_i     (word_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .res_o      (res_o)
);

// File: tb/mul_unit_test.sv
module mul_unit_test;
  localparam int CLK_P = 10;
  localparam int XL    = 8;
  localparam int WW    = 4;
  localparam int CW    = 2;
  localparam int STEPS = XL / CW;
  localparam int FULL  = STEPS + 1;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          in_valid = 1'b0, word = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [XL-1:0] a = '0, b = '0, res;
  logic [2:0]    op = '0;
  int            checks = 0, errors = 0;
  bit            done_f = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mul_unit #(.XLEN(XL), .WORD_W(WW), .CHUNK_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .op_i(op), .word_i(word),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] model(input logic [XL-1:0] x, input logic [XL-1:0] y,
                                          input logic [2:0] o, input logic w);
    longint sx, sy, p;
    logic [63:0] pv;
    if (w) begin
      p = longint'(x[WW-1:0]) * longint'(y[WW-1:0]);
      pv = p;
      return {{(XL-WW){pv[WW-1]}}, pv[WW-1:0]};
    end
    sx = longint'(x);
    sy = longint'(y);
    if (o == 3'b001 || o == 3'b010) if (x[XL-1]) sx = sx - (longint'(1) << XL);
    if (o == 3'b001) if (y[XL-1]) sy = sy - (longint'(1) << XL);
    p = sx * sy;
    pv = p;
    if (o == 3'b001 || o == 3'b010 || o == 3'b011) return pv[2*XL-1:XL];
    return pv[XL-1:0];
  endfunction

  function automatic string req_of(input logic [2:0] o, input logic w);
    if (w) return "R5";
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R6";
    endcase
  endfunction

  // issue one request, check result; exp_lat < 0 skips the latency check
  task automatic run(input logic [XL-1:0] x, input logic [XL-1:0] y, input logic [2:0] o,
                     input logic w, input int hold, input int exp_lat, input string lreq);
    int lat;
    logic [XL-1:0] got;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = x; b = y; op = o; word = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R7", longint'(in_ready), 0);
    lat = 0;
    while (!out_valid) begin
      @(negedge clk);
      lat++;
    end
    got = res;
    chk(got == model(x, y, o, w), req_of(o, w), longint'(got), longint'(model(x, y, o, w)));
    if (exp_lat >= 0) chk(lat == exp_lat, lreq, lat, exp_lat);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && res == got, "R8", longint'(res), longint'(got));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R7", longint'({out_valid, in_ready}), 1);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R12", longint'({out_valid, in_ready}), 1);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_f) begin
      errors++;
      $display("FAIL watchdog R7 actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [XL-1:0] va, vb;
    repeat (2) @(negedge clk);
    chk(!out_valid && in_ready, "R12", longint'({out_valid, in_ready}), 1);
    rst_ni = 1'b1;

    // most-negative corners (R2, R3)
    run(8'h80, 8'h80, 3'b001, 1'b0, 0, FULL, "R9");
    run(8'h80, 8'hff, 3'b001, 1'b0, 0, FULL, "R9");
    run(8'h80, 8'hff, 3'b010, 1'b0, 0, FULL, "R9");
    run(8'hff, 8'h80, 3'b010, 1'b0, 0, FULL, "R9");
    run(8'hff, 8'hff, 3'b011, 1'b0, 0, FULL, "R9");
    run(8'h7f, 8'h80, 3'b001, 1'b0, 2, FULL, "R9");

    // sweep over operand spread and every code
    for (int i = 0; i < 18; i++) begin
      for (int j = 0; j < 18; j++) begin
        va = XL'((i * 37 + 3) % 256);
        vb = XL'((j * 53 + 128) % 256);
        if (i == 0) va = 8'h80;
        if (j == 1) vb = 8'hff;
        for (int o = 0; o < 4; o++) run(va, vb, 3'(o), 1'b0, (i + j + o) % 3, -1, "");
        run(va, vb, 3'(o_rand(i, j)), 1'b1, 0, FULL, "R9");
        if ((i + j) % 5 == 0) run(va, vb, 3'(4 + (i % 4)), 1'b0, 0, -1, "");
      end
    end

    // reuse: low after high on same operands (R10)
    run(8'h9c, 8'h37, 3'b001, 1'b0, 0, FULL, "R11");
    run(8'h9c, 8'h37, 3'b000, 1'b0, 0, 0, "R10");
    run(8'h9c, 8'h37, 3'b001, 1'b0, 1, 0, "R10");
    // different signedness recomputes (R11)
    run(8'h9c, 8'h37, 3'b011, 1'b0, 0, FULL, "R11");
    run(8'h9c, 8'h37, 3'b000, 1'b0, 0, 0, "R10");
    // different operands invalidate (R11)
    run(8'h12, 8'h34, 3'b010, 1'b0, 0, FULL, "R11");
    run(8'h9c, 8'h37, 3'b000, 1'b0, 0, FULL, "R11");
    // word request invalidates (R11)
    run(8'h9c, 8'h37, 3'b000, 1'b1, 0, FULL, "R11");
    run(8'h9c, 8'h37, 3'b000, 1'b0, 0, FULL, "R11");
    run(8'h9c, 8'h37, 3'b101, 1'b0, 0, 0, "R10");
    // reset invalidates (R11, R12)
    pulse_reset();
    run(8'h9c, 8'h37, 3'b000, 1'b0, 0, FULL, "R11");
    // word mode ignores upper bits and code (R5)
    run(8'hf7, 8'ha5, 3'b011, 1'b1, 0, FULL, "R9");
    run(8'h07, 8'h05, 3'b000, 1'b1, 0, FULL, "R9");

    done_f = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int o_rand(input int i, input int j);
    return (i * 3 + j) % 8;
  endfunction
endmodule